// File: doc/BRIEF.md
# Burst column address generator

This block produces the column address of every beat of a memory read or write burst. A start strobe loads a 9-bit starting column together with a burst length code and an ordering choice. From the next cycle on, the block presents one column per clock until the burst ends by itself, is stopped, or is replaced by a new start.

Two orderings are offered. Sequential ordering counts upward inside the aligned block that the burst length defines. Interleaved ordering XORs the low column bits with the beat number. A full-page setting, available only with sequential ordering, walks all 512 columns modulo 512. It runs until a stop strobe arrives. Bank and row handling belong to neighbouring logic.

The length code and the ordering are taken only at a start. A start on any cycle, even in the middle of a burst, replaces the current burst at once.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, `busy_o` and `final_o` are 0 and `col_o` is 0.
- R2: When `start_i` is high at a rising edge, from the next cycle `busy_o` is 1 and `col_o` equals `start_col_i` (beat 0). Each later cycle of the burst presents the next beat.
- R3: Sequential ordering (`ilv_i`=0) uses length codes 0, 1, 2 and 3 for lengths 1, 2, 4 and 8. Beat k keeps the column bits above log2(length) equal to the start column. The low log2(length) bits equal (start + k) modulo length.
- R4: Interleaved ordering (`ilv_i`=1) with a length code of 0 to 3 gives beat k = start column XOR k, where k < length.
- R5: A length code with bit 2 set, used with sequential ordering, selects full page. Beat k is (start + k) modulo 512. The burst never ends by itself, and `final_o` stays 0.
- R6: In a burst of fixed length L, `final_o` is 1 exactly on beat L-1. `busy_o` drops in the following cycle, and `col_o` then holds that last column.
- R7: `stop_i` high at an edge with `start_i` low ends an active burst, so `busy_o` is 0 from the next cycle. If `start_i` is also high, the start takes effect and the stop is ignored.
- R8: A start during an active burst restarts it with beat 0 at the new column, using the new length and ordering.
- R9: A full-page code (bit 2 set) together with interleaved ordering behaves as interleaved length 8.
- R10: Changes of `len_code_i` and `ilv_i` while no start is given, and a stop while idle, do not change `col_o`, `busy_o` or `final_o`.
- R11: While idle, `col_o` holds the last column presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Load a new burst (also replaces one in progress) |
| start_col_i | input | 9 | Starting column |
| len_code_i | input | 3 | Length code: 0..3 give 1, 2, 4, 8; bit 2 set gives full page |
| ilv_i | input | 1 | 1 for interleaved ordering, 0 for sequential |
| stop_i | input | 1 | End the active burst |
| col_o | output | 9 | Current column |
| busy_o | output | 1 | Burst active; `col_o` is a valid beat |
| final_o | output | 1 | Current beat is the last one of a fixed-length burst |

## Verification
The bench targets wrap points. These are a sequential burst that starts mid-block and has to wrap back to the block base rather than carry into upper bits, and a full-page burst that crosses column 511 back to 0. A design that carried would change the upper column bits. One that ended full page at the block edge would drop `busy_o` or raise `final_o`. Further cases are a start coinciding with a stop, which must win, and a restart in mid-burst. Length 1 must end after one beat, interleave combined with full page must fold to length 8, and configuration noise between starts must leave an active burst untouched.

// File: rtl/burst_pkg.sv
package burst_pkg;
  parameter int unsigned BCG_COL_W  = 9;
  parameter int unsigned BCG_CODE_W = 3;
  localparam int unsigned BCG_LOG_W = BCG_CODE_W - 1;

  typedef logic [BCG_COL_W-1:0]  col_t;
  typedef logic [BCG_CODE_W-1:0] code_t;

  typedef struct packed {
    col_t base;
    col_t mask;
    logic full;
    logic ilv;
  } burst_cfg_t;
endpackage

// File: rtl/burst_rst_sync.sv
module burst_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/burst_len_decode.sv
module burst_len_decode
  import burst_pkg::*;
(
  input  code_t code_i,
  input  logic  ilv_i,
  output col_t  mask_o,
  output logic  full_o
);
  localparam int unsigned ILV_CAP_LOG = 3;

  logic           page_sel;
  logic [BCG_LOG_W-1:0] log_len;

  assign page_sel = code_i[BCG_CODE_W-1];

  always_comb begin
    full_o  = page_sel & ~ilv_i;
    log_len = code_i[BCG_LOG_W-1:0];
    if (page_sel && ilv_i) log_len = BCG_LOG_W'(ILV_CAP_LOG);
  end

  for (genvar i = 0; i < BCG_COL_W; i++) begin : g_mask
    assign mask_o[i] = full_o | (i < int'(log_len));
  end
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
  import burst_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic stop_i,
  input  col_t lim_i,
  input  logic full_i,
  output col_t cnt_o,
  output logic active_o,
  output logic last_o
);
  col_t cnt_q, cnt_d;
  logic act_q, act_d;
  logic at_end;
  logic en;

  assign at_end = act_q & ~full_i & (cnt_q == lim_i);
  assign en     = start_i | act_q;

  always_comb begin
    cnt_d = cnt_q;
    act_d = act_q;
    if (start_i) begin
      cnt_d = '0;
      act_d = 1'b1;
    end else if (act_q) begin
      if (stop_i || at_end) act_d = 1'b0;
      else                  cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (en) begin
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  assign cnt_o    = cnt_q;
  assign active_o = act_q;
  assign last_o   = at_end;

  // R2
  start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (active_o && cnt_o == '0));
  // R6
  end_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last_o && !start_i) |=> !active_o);
  // R7
  stop_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && !start_i) |=> !active_o);
  // R3
  beat_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && !start_i && !stop_i && !last_o) |=> (cnt_o == $past(cnt_o) + 1'b1));
endmodule

// File: rtl/burst_addr_map.sv
module burst_addr_map
  import burst_pkg::*;
(
  input  col_t base_i,
  input  col_t cnt_i,
  input  col_t mask_i,
  input  logic ilv_i,
  output col_t col_o
);
  col_t sum;

  assign sum = base_i + cnt_i;

  for (genvar i = 0; i < BCG_COL_W; i++) begin : g_bit
    assign col_o[i] = mask_i[i] ? (ilv_i ? (base_i[i] ^ cnt_i[i]) : sum[i])
                                : base_i[i];
  end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import burst_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic [BCG_COL_W-1:0]  start_col_i,
  input  logic [BCG_CODE_W-1:0] len_code_i,
  input  logic                  ilv_i,
  input  logic                  stop_i,
  output logic [BCG_COL_W-1:0]  col_o,
  output logic                  busy_o,
  output logic                  final_o
);
  logic       rst_sync_n;
  burst_cfg_t cfg_q, cfg_d;
  col_t       new_mask;
  logic       new_full;
  col_t       beat_cnt;

  burst_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  burst_len_decode u_dec (
    .code_i (len_code_i),
    .ilv_i  (ilv_i),
    .mask_o (new_mask),
    .full_o (new_full)
  );

  always_comb begin
    cfg_d.base = start_col_i;
    cfg_d.mask = new_mask;
    cfg_d.full = new_full;
    cfg_d.ilv  = ilv_i;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  cfg_q <= '0;
    else if (start_i) cfg_q <= cfg_d;
  end

  burst_beat_ctr u_ctr (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .start_i  (start_i),
    .stop_i   (stop_i),
    .lim_i    (cfg_q.mask),
    .full_i   (cfg_q.full),
    .cnt_o    (beat_cnt),
    .active_o (busy_o),
    .last_o   (final_o)
  );

  burst_addr_map u_map (
    .base_i (cfg_q.base),
    .cnt_i  (beat_cnt),
    .mask_i (cfg_q.mask),
    .ilv_i  (cfg_q.ilv),
    .col_o  (col_o)
  );

  // R5
  page_no_final_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cfg_q.full |-> !final_o);
  // R3
  upper_fixed_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    busy_o |-> (((col_o ^ cfg_q.base) & ~cfg_q.mask) == '0));
  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!busy_o && !start_i) |=> $stable(col_o));
endmodule

// File: tb/burst_col_gen_tb_top.sv
module burst_col_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       start_i, ilv_i, stop_i;
  logic [8:0] start_col_i;
  logic [2:0] len_code_i;
  logic [8:0] col_o;
  logic       busy_o, final_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [8:0] m_base;
  int         m_cnt, m_len;
  bit         m_act, m_full, m_ilv;

  always #10 clk = ~clk;

  burst_col_gen dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
    .len_code_i(len_code_i), .ilv_i(ilv_i), .stop_i(stop_i),
    .col_o(col_o), .busy_o(busy_o), .final_o(final_o)
  );

  function automatic int exp_len(logic [2:0] code, bit il);
    if (code[2]) return il ? 8 : 512;
    return 1 << code[1:0];
  endfunction

  function automatic logic [8:0] exp_col(logic [8:0] b, int k, int len, bit il);
    logic [8:0] m;
    logic [8:0] kk;
    m  = 9'(len - 1);
    kk = 9'(k);
    if (il) return b ^ (kk & m);
    return (b & ~m) | ((b + kk) & m);
  endfunction

  task automatic chk(string tag, string what, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s got=%0h exp=%0h", tag, what, got, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk(tag, "col", int'(col_o), int'(exp_col(m_base, m_cnt, m_len, m_ilv)));
    chk(tag, "busy", int'(busy_o), int'(m_act));
    chk(tag, "final", int'(final_o), int'(m_act && !m_full && m_cnt == m_len - 1));
  endtask

  task automatic step(bit st, logic [8:0] c, logic [2:0] code, bit il, bit sp, string tag);
    start_i = st; start_col_i = c; len_code_i = code; ilv_i = il; stop_i = sp;
    if (st) begin
      m_base = c; m_len = exp_len(code, il); m_full = code[2] && !il;
      m_ilv = il; m_cnt = 0; m_act = 1;
    end else if (m_act) begin
      if (sp || (!m_full && m_cnt == m_len - 1)) m_act = 0;
      else m_cnt = (m_cnt + 1) % 512;
    end
    @(negedge clk);
    if (tag == "") check_all(m_full ? "R5" : (m_ilv ? "R4" : "R3"));
    else           check_all(tag);
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) step(0, 9'h0AA, 3'($urandom_range(7)), 1'($urandom_range(1)), 0, tag);
  endtask

  initial begin
    void'($urandom(32'd4242));
    rst_n = 0; start_i = 0; start_col_i = 0; len_code_i = 0; ilv_i = 0; stop_i = 0;
    m_base = 0; m_cnt = 0; m_len = 1; m_act = 0; m_full = 0; m_ilv = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R1", "col", int'(col_o), 0);
    chk("R1", "busy", int'(busy_o), 0);
    chk("R1", "final", int'(final_o), 0);

    // R2 / R3: sequential length 4 starting mid-block, wraps to block base
    step(1, 9'h10D, 3'd2, 0, 0, "R2");
    for (int i = 0; i < 4; i++) step(0, 9'h000, 3'd2, 0, 0, "R3");
    idle(2, "R11");
    // R3 sequential length 8
    step(1, 9'h0F6, 3'd3, 0, 0, "R3");
    for (int i = 0; i < 8; i++) step(0, 0, 0, 0, 0, "R3");
    // R4 interleave length 8 and 2
    step(1, 9'h1A5, 3'd3, 1, 0, "R4");
    for (int i = 0; i < 8; i++) step(0, 0, 0, 0, 0, "R4");
    step(1, 9'h033, 3'd1, 1, 0, "R4");
    for (int i = 0; i < 2; i++) step(0, 0, 0, 0, 0, "R4");
    // R6 length 1
    step(1, 9'h155, 3'd0, 0, 0, "R6");
    step(0, 0, 0, 0, 0, "R6");
    idle(2, "R11");
    // R5 full page across 511 -> 0, long run
    step(1, 9'h1FC, 3'd4, 0, 0, "R5");
    for (int i = 0; i < 530; i++) step(0, 0, 3'($urandom_range(7)), 1'($urandom_range(1)), 0, "R5");
    // R7 stop ends full page
    step(0, 0, 0, 0, 1, "R7");
    idle(3, "R11");
    // R10 stop while idle
    step(0, 9'h1FF, 3'd7, 1, 1, "R10");
    // R7 start and stop together: start wins
    step(1, 9'h040, 3'd3, 0, 1, "R7");
    step(0, 0, 0, 0, 0, "R7");
    // R8 restart mid-burst with new settings
    step(1, 9'h0C7, 3'd2, 1, 0, "R8");
    step(0, 0, 0, 0, 0, "R8");
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0, "R8");
    // R9 full-page code with interleave acts as length 8
    step(1, 9'h12B, 3'd6, 1, 0, "R9");
    for (int i = 0; i < 9; i++) step(0, 0, 0, 0, 0, "R9");
    // R10 config noise mid-burst has no effect
    step(1, 9'h081, 3'd3, 0, 0, "R10");
    for (int i = 0; i < 9; i++) step(0, 9'h1FF, 3'($urandom_range(7)), 1'($urandom_range(1)), 0, "R10");

    // random mix
    for (int i = 0; i < 4000; i++) begin
      bit st, sp;
      st = ($urandom_range(m_act ? 11 : 3) == 0);
      sp = ($urandom_range(19) == 0);
      step(st, 9'($urandom_range(511)), 3'($urandom_range(7)), 1'($urandom_range(1)), sp, "");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired got=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule